// File: doc/BRIEF.md
# Programmable Color Space Matrix

This block converts a stream of three-component pixels between RGB and YCbCr. Each output component is a weighted sum of the three input components. The weights form a 3x3 matrix that is loaded at run time. Because the conversion direction comes only from the loaded weights, the same hardware serves both directions.

Before the multiply, each input channel has its own signed offset added. After the multiply, each output channel has a second, independent offset added. This lets the block remove a black-level or chroma bias on the way in and restore one on the way out. Every pixel crosses a fixed three-stage pipeline, and a valid flag travels with it.

A simple write port loads the configuration into a shadow copy. The shadow is copied into the working set only when the block holds no pixel. As a result, no pixel is ever computed with a mix of old and new settings. When the block is disabled, pixels pass through unchanged with the same latency.

Top module: `csc_matrix`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `out_valid` and all three output components are 0. Reset loads the identity matrix (diagonal 0x1000), zero offsets and enable 0.
- R2: `out_valid` equals `in_valid` delayed by exactly 3 clock edges, whether the block is enabled or bypassed.
- R3: When enable is 0, each output component equals the matching input component from 3 edges earlier. Offsets and coefficients have no effect in this mode.
- R4: When enable is 1, output k is computed as follows. First form the sum over j of Ckj·(in_j + ioff_j). Then round it, add ooff_k, and clamp the result. Coefficients are signed 16-bit values with 12 fraction bits (0x1000 = 1.0). Offsets are signed 13-bit values.
- R5: The scaled sum is rounded to the nearest integer, with exact halves rounded toward +infinity. For example, 2.5 becomes 3 and −4.5 becomes −4.
- R6: After the output offset is added, results below 0 become 0 and results above 4095 become 4095.
- R7: The write port map is as follows. Address 3·k+j (0..8) holds coefficient Ckj, taken from data[15:0]. Addresses 9..11 hold the input offsets for channels 0..2, taken from data[12:0]. Addresses 12..14 hold the output offsets for channels 0..2, also from data[12:0]. Address 15 bit 0 holds enable.
- R8: A write changes only the shadow copy. The working set takes the shadow on an edge only if `in_valid` is low and no pixel is inside the pipeline. Pixels already streaming therefore keep the settings they started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| in_valid | input | 1 | Input pixel valid |
| in_c0 | input | 12 | Input component 0 (R or Y) |
| in_c1 | input | 12 | Input component 1 (G or Cb) |
| in_c2 | input | 12 | Input component 2 (B or Cr) |
| out_valid | output | 1 | Output pixel valid |
| out_c0 | output | 12 | Output component 0 |
| out_c1 | output | 12 | Output component 1 |
| out_c2 | output | 12 | Output component 2 |

## Verification
The enabled matrix mixes whole, half, quarter and negative weights, together with nonzero offsets on both sides. Each vector therefore shows whether the inputs are routed to the correct rows, and whether offsets are applied on the correct side of the multiply. Some vectors are chosen so that the scaled sum lands exactly on a positive half and a negative half; these separate round-half-up from truncation and from round-half-away. All-zero and all-full-scale pixels drive outputs past both clamp limits.

Bypass is tested twice: first with the reset identity, and then with offsets loaded but disabled. This confirms that the loaded values are ignored in bypass. A back-to-back burst with an enable write in its second pixel must come out fully bypassed. The next pixel after a gap must come out converted.

// File: rtl/csc_pkg.sv
package csc_pkg;
    localparam int DW    = 12;            // component width
    localparam int CW    = 16;            // coefficient width
    localparam int FRAC  = 12;            // coefficient fraction bits
    localparam int OFW   = 13;            // offset width
    localparam int NCH   = 3;             // channels
    localparam int ADW   = 4;             // config address width
    localparam int BW    = DW + 2;        // biased input, signed
    localparam int PW    = BW + CW;       // one product
    localparam int AW    = PW + 2;        // sum of three products
    localparam int IOFF_BASE = NCH * NCH;
    localparam int OOFF_BASE = IOFF_BASE + NCH;
    localparam int EN_ADDR   = OOFF_BASE + NCH;

    typedef logic        [DW-1:0]  comp_t;
    typedef logic signed [BW-1:0]  bias_t;
    typedef logic signed [AW-1:0]  acc_t;
    typedef logic signed [CW-1:0]  coef_t;
    typedef logic signed [OFW-1:0] off_t;

    typedef struct packed {
        logic                              en;
        logic [NCH-1:0][NCH-1:0][CW-1:0]   coef;
        logic [NCH-1:0][OFW-1:0]           ioff;
        logic [NCH-1:0][OFW-1:0]           ooff;
    } cfg_t;

    function automatic cfg_t cfg_reset();
        cfg_t c;
        c = '0;
        for (int r = 0; r < NCH; r++)
            c.coef[r][r] = CW'(1 << FRAC);
        return c;
    endfunction

    function automatic bias_t add_ioff(comp_t x, logic [OFW-1:0] o);
        return $signed({2'b00, x}) + bias_t'($signed(o));
    endfunction

    function automatic comp_t round_sat(acc_t acc, logic [OFW-1:0] o);
        acc_t t;
        acc_t r;
        t = acc + (acc_t'(1) <<< (FRAC - 1));
        r = (t >>> FRAC) + acc_t'($signed(o));
        if (r < 0)
            return '0;
        else if (r > acc_t'({1'b0, {DW{1'b1}}}))
            return '1;
        else
            return comp_t'(r);
    endfunction
endpackage

// File: rtl/csc_cfg_regs.sv
module csc_cfg_regs
    import csc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [ADW-1:0]  addr,
    input  logic [CW-1:0]   wdata,
    input  logic            apply,
    output cfg_t            act
);
    cfg_t shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= cfg_reset();
            act    <= cfg_reset();
        end else begin
            if (we) begin
                for (int r = 0; r < NCH; r++)
                    for (int c = 0; c < NCH; c++)
                        if (addr == ADW'(r * NCH + c))
                            shadow.coef[r][c] <= wdata;
                for (int i = 0; i < NCH; i++) begin
                    if (addr == ADW'(IOFF_BASE + i))
                        shadow.ioff[i] <= wdata[OFW-1:0];
                    if (addr == ADW'(OOFF_BASE + i))
                        shadow.ooff[i] <= wdata[OFW-1:0];
                end
                if (addr == ADW'(EN_ADDR))
                    shadow.en <= wdata[0];
            end
            if (apply)
                act <= shadow;
        end
    end
endmodule

// File: rtl/csc_row.sv
module csc_row
    import csc_pkg::*;
(
    input  logic [NCH-1:0][BW-1:0] x,
    input  logic [NCH-1:0][CW-1:0] c,
    output acc_t                   sum
);
    always_comb begin
        sum = '0;
        for (int j = 0; j < NCH; j++)
            sum = sum + acc_t'($signed(x[j])) * acc_t'($signed(c[j]));
    end
endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
    import csc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [3:0]  cfg_addr,
    input  logic [15:0] cfg_wdata,
    input  logic        in_valid,
    input  logic [11:0] in_c0,
    input  logic [11:0] in_c1,
    input  logic [11:0] in_c2,
    output logic        out_valid,
    output logic [11:0] out_c0,
    output logic [11:0] out_c1,
    output logic [11:0] out_c2
);
    cfg_t                   act;
    logic                   apply;
    logic [NCH-1:0][DW-1:0] pin;
    // stage 1: biased inputs
    logic                   v1;
    logic [NCH-1:0][BW-1:0] b1;
    logic [NCH-1:0][DW-1:0] raw1;
    // stage 2: matrix sums
    logic                   v2;
    acc_t [NCH-1:0]         s2;
    acc_t [NCH-1:0]         row_sum;
    logic [NCH-1:0][DW-1:0] raw2;
    // stage 3: outputs
    logic [NCH-1:0][DW-1:0] pout;

    assign pin   = {in_c2, in_c1, in_c0};
    assign apply = !in_valid && !v1 && !v2;

    csc_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .apply (apply),
        .act   (act)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_row
        csc_row u_row (
            .x   (b1),
            .c   (act.coef[k]),
            .sum (row_sum[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v1        <= 1'b0;
            b1        <= '0;
            raw1      <= '0;
            v2        <= 1'b0;
            s2        <= '0;
            raw2      <= '0;
            out_valid <= 1'b0;
            pout      <= '0;
        end else begin
            v1        <= in_valid;
            raw1      <= pin;
            v2        <= v1;
            raw2      <= raw1;
            s2        <= row_sum;
            out_valid <= v2;
            for (int i = 0; i < NCH; i++) begin
                b1[i]   <= add_ioff(pin[i], act.ioff[i]);
                pout[i] <= act.en ? round_sat(s2[i], act.ooff[i]) : raw2[i];
            end
        end
    end

    assign out_c0 = pout[0];
    assign out_c1 = pout[1];
    assign out_c2 = pout[2];
endmodule

// File: rtl/csc_matrix_chk.sv
module csc_matrix_chk
    import csc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [11:0] in_c0,
    input logic [11:0] in_c1,
    input logic [11:0] in_c2,
    input logic        out_valid,
    input logic [11:0] out_c0,
    input logic [11:0] out_c1,
    input logic [11:0] out_c2,
    input logic        v1,
    input logic        v2,
    input cfg_t        act
);
    logic [1:0] since;

    always_ff @(posedge clk) begin
        if (rst)
            since <= '0;
        else if (since != 2'd3)
            since <= since + 2'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_c0 == '0 && out_c1 == '0 && out_c2 == '0));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R3
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (since == 2'd3 && out_valid && !act.en) |->
        ({out_c2, out_c1, out_c0} == $past({in_c2, in_c1, in_c0}, 3)));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid || v1 || v2) |=> $stable(act));
endmodule

bind csc_matrix csc_matrix_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_c0     (in_c0),
    .in_c1     (in_c1),
    .in_c2     (in_c2),
    .out_valid (out_valid),
    .out_c0    (out_c0),
    .out_c1    (out_c1),
    .out_c2    (out_c2),
    .v1        (v1),
    .v2        (v2),
    .act       (act)
);

// File: tb/csc_matrix_bench.sv
module csc_matrix_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {in0, in1, in2, exp0, exp1, exp2}, matrix and offsets set in run
    localparam logic [71:0] VEC [NVEC] = '{
        {12'd100,  12'd200,  12'd300,  12'd184,  12'd1948, 12'd334},
        {12'd17,   12'd3,    12'd0,    12'd3,    12'd2070, 12'd44},
        {12'd0,    12'd0,    12'd0,    12'd0,    12'd2073, 12'd34},
        {12'd4095, 12'd4095, 12'd4095, 12'd4095, 12'd0,    12'd4095},
        {12'd16,   12'd1,    12'd2,    12'd1,    12'd2073, 12'd44},
        {12'd16,   12'd30,   12'd2,    12'd15,   12'd2044, 12'd58}
    };
    localparam string VREQ [NVEC] = '{"R4", "R5", "R6", "R6", "R5", "R5"};

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        in_valid;
    logic [11:0] in_c0, in_c1, in_c2;
    logic        out_valid;
    logic [11:0] out_c0, out_c1, out_c2;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    csc_matrix u_csc_matrix (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .in_valid  (in_valid),
        .in_c0     (in_c0),
        .in_c1     (in_c1),
        .in_c2     (in_c2),
        .out_valid (out_valid),
        .out_c0    (out_c0),
        .out_c1    (out_c1),
        .out_c2    (out_c2)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_pix(input string req, input int e0, input int e1, input int e2);
        chk(req, "out_valid", int'(out_valid), 1);
        chk(req, "out_c0", int'(out_c0), e0);
        chk(req, "out_c1", int'(out_c1), e1);
        chk(req, "out_c2", int'(out_c2), e2);
    endtask

    task automatic cfg_write(input int a, input int d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 4'(a);
        cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we    = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input string req, input int a, input int b, input int c,
                        input int e0, input int e1, input int e2);
        @(negedge clk);
        in_valid = 1'b1;
        in_c0 = 12'(a); in_c1 = 12'(b); in_c2 = 12'(c);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2", "out_valid early", int'(out_valid), 0);
        @(negedge clk);
        chk_pix(req, e0, e1, e2);
        @(negedge clk);
        chk("R2", "out_valid after", int'(out_valid), 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : run
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        in_valid = 1'b0; in_c0 = '0; in_c1 = '0; in_c2 = '0;
        repeat (4) @(negedge clk);
        // R1: outputs cleared during reset
        chk("R1", "out_valid in reset", int'(out_valid), 0);
        chk("R1", "out_c0 in reset", int'(out_c0), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        chk("R1", "out_c2 after reset", int'(out_c2), 0);

        // R3: reset default is bypass
        send("R3", 123, 456, 789, 123, 456, 789);

        // R7: load matrix and offsets, still disabled
        cfg_write(0, 4096);  cfg_write(1, 2048);  cfg_write(2, 0);
        cfg_write(3, 0);     cfg_write(4, 16'hF000); cfg_write(5, 1024);
        cfg_write(6, 2048);  cfg_write(7, 2048);  cfg_write(8, 2048);
        cfg_write(9, 16'hFFF0); cfg_write(10, 0); cfg_write(11, 100);
        cfg_write(12, 0);    cfg_write(13, 2048); cfg_write(14, 16'hFFF8);

        // R3: loaded offsets and weights ignored while disabled
        send("R3", 4095, 0, 7, 4095, 0, 7);

        // R8: enable written inside a burst must not touch the burst
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (k >= 3 && k < 7)
                chk_pix("R8", 10 + k - 3, 20 + k - 3, 30 + k - 3);
            if (k == 7)
                chk("R2", "out_valid burst end", int'(out_valid), 0);
            if (k < 4) begin
                in_valid = 1'b1;
                in_c0 = 12'(10 + k); in_c1 = 12'(20 + k); in_c2 = 12'(30 + k);
            end else begin
                in_valid = 1'b0;
            end
            cfg_we    = (k == 1);
            cfg_addr  = 4'd15;
            cfg_wdata = 16'd1;
        end
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);

        // R4 R5 R6: enabled conversion table
        for (int i = 0; i < NVEC; i++) begin
            send(VREQ[i],
                 int'(VEC[i][71:60]), int'(VEC[i][59:48]), int'(VEC[i][47:36]),
                 int'(VEC[i][35:24]), int'(VEC[i][23:12]), int'(VEC[i][11:0]));
        end

        // R3 R7: disable via address 15 returns to pass-through
        cfg_write(15, 0);
        send("R3", 1, 2048, 4094, 1, 2048, 4094);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule